// File: doc/BRIEF.md
# TDM Time Slot Interchange Switch

This block switches voice bytes between four serial receive streams and four serial transmit streams on a TDM backplane. Each stream carries 128 eight-bit channels per 125 µs frame, one bit per cycle of the 8.192 MHz bit clock, for 1024 bit cycles per frame. Every received byte of a frame is stored in a data memory. During the next frame, each output channel of each transmit stream sends the byte that its connection entry selects, so any input channel can reach any output channel and the switch is non-blocking.

The data memory has two banks that alternate by frame parity. One bank is written while the other is read, so every routed byte arrives exactly one frame after it was received. A host register port writes a shadow copy of the connection memory. The whole shadow copy becomes active at the next frame boundary, so no output channel ever carries a mixture of old and new routing. Each connection entry has its own output-enable bit, and a global disable input gates all outputs. A control register turns on a diagnostic loopback per stream, which feeds a stream's transmit line back into its own receive path.

Top module: `tsi_switch`

## Requirements
- R1: After reset, every `tx_oe` bit is low, every `tx_ser` bit is 0, loopback is off on all streams, and reads of any connection entry and of the control register return 0.
- R2: When `frame_pulse` is sampled high at a rising edge, the next 1024 clock cycles form one frame: channel c occupies cycles 8c to 8c+7, most significant bit first. `tx_ser` changes just after each edge, and `rx_ser` is sampled at the edge that ends each cycle. If no pulse arrives, the frame wraps by itself after 1024 cycles.
- R3: A host write to address {bit9=0, [8:7]=output stream, [6:0]=output channel} stores the word {[9]=enable, [8:7]=source stream, [6:0]=source channel}. Any source channel can go to any output channel, and one source can feed several outputs.
- R4: A byte received during frame N appears on its routed outputs during frame N+1.
- R5: An output slot whose active entry has enable=0 drives `tx_oe` low and `tx_ser` 0 for that slot.
- R6: While `out_disable` is high, every `tx_oe` bit is low and every `tx_ser` bit is 0 in the same cycle. Routing resumes unchanged once the input drops.
- R7: The host writes at a rising edge with `host_cs`=1 and `host_we`=1. A connection change applies only from the next frame start. A read (`host_cs`=1, `host_we`=0) returns the stored word on `host_rdata` from the next cycle onward.
- R8: While loopback bit k is set, stream k stores its own `tx_ser[k]` as receive data and ignores `rx_ser[k]`. Clearing the bit restores the external input.
- R9: The control register sits at any address with bit 9 = 1. Its `wdata[3:0]` are the loopback bits for streams 3..0. The register takes effect from the next cycle and reads back zero-extended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock (8.192 MHz nominal) |
| rst_n | input | 1 | Asynchronous reset, active low |
| frame_pulse | input | 1 | Frame start marker, sampled on rising edge |
| rx_ser | input | 4 | Serial receive data, one bit per stream |
| out_disable | input | 1 | Global output disable |
| host_cs | input | 1 | Host access strobe |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | 10 | Connection entry or control register address |
| host_wdata | input | 10 | Host write data |
| host_rdata | output | 10 | Registered host read data |
| tx_ser | output | 4 | Serial transmit data, one bit per stream |
| tx_oe | output | 4 | Per-stream output enable for the current slot (0 = high impedance) |

## Verification
The bench aims at the extremes of the frame: channel 0 on stream 0 and channel 127 on streams 2 and 3. A wrong bit order or an off-by-one in the slot counter would scramble or shift exactly these bytes. A connection entry is rewritten in the middle of a frame, after its slot has already passed. A design that applied writes at once would send the new source one frame early. A frame boundary is left to the free-running wrap with no pulse, which catches a counter that stalls or drifts. The loopback test chains two frames through a looped stream while the external line carries different data, so a switch that still listened to the pin, or failed to resume it after loopback is cleared, sends the wrong byte.

// File: rtl/tsi_pkg.sv
`timescale 1ns/1ps
package tsi_pkg;
  localparam int BYTE_W = 8;

  // Bit index carried in a given cycle of a channel slot (MSB leads).
  function automatic logic [2:0] msb_index(input logic [2:0] phase);
    return 3'(BYTE_W - 1) - phase;
  endfunction

  // True in the last bit cycle of a slot, when a received byte is complete.
  function automatic logic slot_last(input logic [2:0] phase);
    return phase == 3'(BYTE_W - 1);
  endfunction
endpackage

// File: rtl/tsi_frame_timer.sv
`timescale 1ns/1ps
module tsi_frame_timer import tsi_pkg::*; #(
  parameter int NCHAN = 128,
  localparam int POS_W = $clog2(NCHAN * BYTE_W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_pulse,
  output logic [POS_W-1:0] pos,
  output logic             wbank,
  output logic             frame_start
);
  localparam logic [POS_W-1:0] LAST_POS = POS_W'(NCHAN * BYTE_W - 1);

  assign frame_start = frame_pulse || (pos == LAST_POS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos   <= '0;
      wbank <= 1'b0;
    end else begin
      pos <= frame_start ? '0 : pos + 1'b1;
      if (frame_start) wbank <= ~wbank;
    end
  end

  AST_PULSE_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
    frame_pulse |=> (pos == '0)); // R2
  AST_BANK_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> (wbank != $past(wbank))); // R4
endmodule

// File: rtl/tsi_rx_deser.sv
`timescale 1ns/1ps
module tsi_rx_deser import tsi_pkg::*; #(
  parameter int NSTREAM = 4
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [NSTREAM-1:0]             rx_in,
  input  logic [2:0]                     phase,
  output logic                           byte_done,
  output logic [NSTREAM-1:0][BYTE_W-1:0] rx_byte
);
  assign byte_done = slot_last(phase);

  for (genvar g = 0; g < NSTREAM; g++) begin : g_lane
    logic [BYTE_W-2:0] shreg;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) shreg <= '0;
      else        shreg <= {shreg[BYTE_W-3:0], rx_in[g]};
    end
    assign rx_byte[g] = {shreg, rx_in[g]};
  end

  AST_BYTE_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    byte_done |=> (phase == 3'd0)); // R2
endmodule

// File: rtl/tsi_conn_mem.sv
`timescale 1ns/1ps
module tsi_conn_mem #(
  parameter int NSTREAM = 4,
  parameter int NCHAN = 128,
  localparam int SW = $clog2(NSTREAM),
  localparam int CW = $clog2(NCHAN),
  localparam int IDX_W = SW + CW,
  localparam int EW = IDX_W + 1,
  localparam int ADDR_W = IDX_W + 1,
  localparam int NENT = NSTREAM * NCHAN
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       frame_start,
  input  logic [CW-1:0]              cur_chan,
  input  logic                       host_cs,
  input  logic                       host_we,
  input  logic [ADDR_W-1:0]          host_addr,
  input  logic [EW-1:0]              host_wdata,
  output logic [EW-1:0]              host_rdata,
  output logic [NSTREAM-1:0]         src_oe,
  output logic [NSTREAM-1:0][SW-1:0] src_stream,
  output logic [NSTREAM-1:0][CW-1:0] src_chan,
  output logic [NSTREAM-1:0]         loop_en
);
  logic [EW-1:0] shadow [NENT];
  logic [EW-1:0] active [NENT];

  logic             host_wr, host_rd, sel_ctrl;
  logic [IDX_W-1:0] sel_idx;
  assign host_wr  = host_cs && host_we;
  assign host_rd  = host_cs && !host_we;
  assign sel_ctrl = host_addr[ADDR_W-1];
  assign sel_idx  = host_addr[IDX_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NENT; i++) begin
        shadow[i] <= '0;
        active[i] <= '0;
      end
      loop_en    <= '0;
      host_rdata <= '0;
    end else begin
      if (host_wr && !sel_ctrl) shadow[sel_idx] <= host_wdata;
      if (host_wr && sel_ctrl)  loop_en <= host_wdata[NSTREAM-1:0];
      if (frame_start)
        for (int i = 0; i < NENT; i++) active[i] <= shadow[i];
      if (host_rd) host_rdata <= sel_ctrl ? EW'(loop_en) : shadow[sel_idx];
    end
  end

  for (genvar g = 0; g < NSTREAM; g++) begin : g_port
    logic [EW-1:0] word;
    assign word          = active[{SW'(g), cur_chan}];
    assign src_chan[g]   = word[CW-1:0];
    assign src_stream[g] = word[CW +: SW];
    assign src_oe[g]     = word[EW-1];
  end

  AST_SHADOW_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && !sel_ctrl) |=> (shadow[$past(sel_idx)] == $past(host_wdata))); // R3
  AST_HOLD_MIDFRAME: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && !sel_ctrl && !frame_start) |=> (active[$past(sel_idx)] == $past(active[sel_idx]))); // R7
  AST_COPY_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> (active[$past(sel_idx)] == $past(shadow[sel_idx]))); // R7
  AST_CTRL_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && sel_ctrl) |=> (loop_en == $past(host_wdata[NSTREAM-1:0]))); // R9
endmodule

// File: rtl/tsi_switch.sv
`timescale 1ns/1ps
module tsi_switch import tsi_pkg::*; #(
  parameter int NSTREAM = 4,
  parameter int NCHAN = 128,
  localparam int SW = $clog2(NSTREAM),
  localparam int CW = $clog2(NCHAN),
  localparam int IDX_W = SW + CW,
  localparam int EW = IDX_W + 1,
  localparam int ADDR_W = IDX_W + 1,
  localparam int NENT = NSTREAM * NCHAN,
  localparam int POS_W = CW + 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               frame_pulse,
  input  logic [NSTREAM-1:0] rx_ser,
  input  logic               out_disable,
  input  logic               host_cs,
  input  logic               host_we,
  input  logic [ADDR_W-1:0]  host_addr,
  input  logic [EW-1:0]      host_wdata,
  output logic [EW-1:0]      host_rdata,
  output logic [NSTREAM-1:0] tx_ser,
  output logic [NSTREAM-1:0] tx_oe
);
  logic [POS_W-1:0] pos;
  logic             wbank, frame_start;
  logic [2:0]       phase;
  logic [CW-1:0]    cur_chan;

  tsi_frame_timer #(.NCHAN(NCHAN)) u_timer (
    .clk(clk), .rst_n(rst_n), .frame_pulse(frame_pulse),
    .pos(pos), .wbank(wbank), .frame_start(frame_start)
  );
  assign phase    = pos[2:0];
  assign cur_chan = pos[POS_W-1:3];

  logic [NSTREAM-1:0]         src_oe, loop_en;
  logic [NSTREAM-1:0][SW-1:0] src_stream;
  logic [NSTREAM-1:0][CW-1:0] src_chan;

  tsi_conn_mem #(.NSTREAM(NSTREAM), .NCHAN(NCHAN)) u_conn (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .cur_chan(cur_chan),
    .host_cs(host_cs), .host_we(host_we), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata),
    .src_oe(src_oe), .src_stream(src_stream), .src_chan(src_chan),
    .loop_en(loop_en)
  );

  logic [NSTREAM-1:0]             rx_in;
  logic                           byte_done;
  logic [NSTREAM-1:0][BYTE_W-1:0] rx_byte;

  tsi_rx_deser #(.NSTREAM(NSTREAM)) u_deser (
    .clk(clk), .rst_n(rst_n), .rx_in(rx_in), .phase(phase),
    .byte_done(byte_done), .rx_byte(rx_byte)
  );

  // Two frame banks: written by wbank, read from the other one.
  logic [BYTE_W-1:0] dmem [2][NENT];

  always_ff @(posedge clk) begin
    if (byte_done)
      for (int s = 0; s < NSTREAM; s++)
        dmem[wbank][{SW'(s), cur_chan}] <= rx_byte[s];
  end

  for (genvar g = 0; g < NSTREAM; g++) begin : g_tx
    logic [BYTE_W-1:0] src_byte;
    logic              drive;
    assign src_byte  = dmem[~wbank][{src_stream[g], src_chan[g]}];
    assign drive     = src_oe[g] && !out_disable;
    assign tx_oe[g]  = drive;
    assign tx_ser[g] = drive && src_byte[msb_index(phase)];
    assign rx_in[g]  = loop_en[g] ? tx_ser[g] : rx_ser[g];
  end

  AST_OE_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_oe == '0) |-> (tx_ser == '0)); // R5
  AST_DISABLE_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    out_disable |-> (tx_oe == '0)); // R6
endmodule

// File: tb/tsi_switch_test.sv
`timescale 1ns/1ps
module tsi_switch_test;
  localparam int FL = 1024;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic       rst_n, frame_pulse, out_disable, host_cs, host_we;
  logic [3:0] rx_ser;
  logic [9:0] host_addr, host_wdata;
  wire  [9:0] host_rdata;
  wire  [3:0] tx_ser, tx_oe;

  tsi_switch uut (
    .clk(clk), .rst_n(rst_n), .frame_pulse(frame_pulse), .rx_ser(rx_ser),
    .out_disable(out_disable), .host_cs(host_cs), .host_we(host_we),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .tx_ser(tx_ser), .tx_oe(tx_oe)
  );

  int total = 0, bad = 0, fr = 0;
  logic [7:0] rx_frm [4][128];
  logic [7:0] last_rx [4][128];
  logic [7:0] prev_rx [4][128];
  logic [7:0] tx_cap [4][128];
  logic       oe_all [4][128];
  logic       oe_any [4][128];
  int         n_ops = 0;
  int         op_pos [8];
  logic       op_we [8];
  logic [9:0] op_addr [8], op_data [8], op_rd [8];
  int         dis_lo = -1, dis_hi = -2;
  logic       pulse_at_end = 1'b1;
  logic [7:0] hold_h, hold_k;

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input int s, input int c, input int f);
    return 8'((s * 61 + c * 7 + f * 29 + 17) ^ (c << 3) ^ (f << 5));
  endfunction

  function automatic logic [9:0] ent(input logic oe, input int s, input int c);
    return {oe, 2'(s), 7'(c)};
  endfunction

  function automatic logic [9:0] adr(input int s, input int c);
    return {1'b0, 2'(s), 7'(c)};
  endfunction

  function automatic int count_en();
    int n = 0;
    for (int s = 0; s < 4; s++)
      for (int c = 0; c < 128; c++)
        if (oe_any[s][c]) n++;
    return n;
  endfunction

  task automatic add_op(input int p, input logic we, input logic [9:0] a, input logic [9:0] d);
    op_pos[n_ops] = p; op_we[n_ops] = we; op_addr[n_ops] = a; op_data[n_ops] = d;
    n_ops++;
  endtask

  task automatic run_frame();
    for (int s = 0; s < 4; s++)
      for (int c = 0; c < 128; c++) begin
        tx_cap[s][c] = '0; oe_all[s][c] = 1'b1; oe_any[s][c] = 1'b0;
      end
    for (int p = 0; p < FL; p++) begin
      int ch;
      int b;
      @(negedge clk);
      ch = p / 8;
      b = 7 - (p % 8);
      for (int s = 0; s < 4; s++) rx_ser[s] = rx_frm[s][ch][b];
      out_disable = (p >= dis_lo) && (p <= dis_hi);
      host_cs = 1'b0; host_we = 1'b0;
      for (int i = 0; i < n_ops; i++) begin
        if (op_pos[i] == p) begin
          host_cs = 1'b1; host_we = op_we[i]; host_addr = op_addr[i]; host_wdata = op_data[i];
        end
        if (op_pos[i] + 1 == p && !op_we[i]) op_rd[i] = host_rdata;
      end
      frame_pulse = (p == FL - 1) ? pulse_at_end : 1'b0;
      #1;
      for (int s = 0; s < 4; s++) begin
        tx_cap[s][ch][b] = tx_ser[s];
        oe_all[s][ch] = oe_all[s][ch] & tx_oe[s];
        oe_any[s][ch] = oe_any[s][ch] | tx_oe[s];
      end
    end
  endtask

  task automatic next_frame();
    prev_rx = last_rx;
    for (int s = 0; s < 4; s++)
      for (int c = 0; c < 128; c++) rx_frm[s][c] = pat(s, c, fr);
    run_frame();
    last_rx = rx_frm;
    fr++;
    n_ops = 0;
  endtask

  task automatic t_reset();
    check("R1", "tx_oe after reset", 32'(tx_oe), 32'h0);
    check("R1", "tx_ser after reset", 32'(tx_ser), 32'h0);
    @(negedge clk); frame_pulse = 1'b1;
    @(posedge clk);
    add_op(0, 1'b0, adr(2, 5), '0);
    add_op(3, 1'b0, 10'h200, '0);
    next_frame();
    check("R1", "entry readback", 32'(op_rd[0]), 32'h0);
    check("R1", "control readback", 32'(op_rd[1]), 32'h0);
    check("R1", "enabled slots", count_en(), 0);
  endtask

  task automatic t_route();
    add_op(0, 1'b1, adr(0, 0), ent(1'b1, 3, 127));
    add_op(1, 1'b1, adr(1, 64), ent(1'b1, 0, 0));
    add_op(2, 1'b1, adr(2, 127), ent(1'b1, 2, 5));
    add_op(3, 1'b1, adr(3, 10), ent(1'b1, 0, 0));
    next_frame();
    check("R7", "no routing before boundary", count_en(), 0);
    add_op(0, 1'b0, adr(1, 64), '0);
    pulse_at_end = 1'b0;
    next_frame();
    check("R7", "readback word", 32'(op_rd[0]), 32'(ent(1'b1, 0, 0)));
    check("R3", "s0c0 from s3c127", 32'(tx_cap[0][0]), 32'(prev_rx[3][127]));
    check("R4", "s1c64 from s0c0", 32'(tx_cap[1][64]), 32'(prev_rx[0][0]));
    check("R2", "s2c127 from s2c5", 32'(tx_cap[2][127]), 32'(prev_rx[2][5]));
    check("R3", "broadcast s3c10", 32'(tx_cap[3][10]), 32'(prev_rx[0][0]));
    check("R5", "enabled slots", count_en(), 4);
    check("R5", "enable held whole slot", 32'(oe_all[2][127]), 32'h1);
    pulse_at_end = 1'b1;
    next_frame();
    check("R2", "after free wrap s0c0", 32'(tx_cap[0][0]), 32'(prev_rx[3][127]));
    check("R2", "after free wrap s2c127", 32'(tx_cap[2][127]), 32'(prev_rx[2][5]));
  endtask

  task automatic t_midframe();
    add_op(600, 1'b1, adr(1, 64), ent(1'b1, 1, 1));
    next_frame();
    check("R7", "old route kept mid frame", 32'(tx_cap[1][64]), 32'(prev_rx[0][0]));
    next_frame();
    check("R7", "new route next frame", 32'(tx_cap[1][64]), 32'(prev_rx[1][1]));
  endtask

  task automatic t_disable();
    dis_lo = 80; dis_hi = 87;
    next_frame();
    dis_lo = -1; dis_hi = -2;
    check("R6", "oe during disable", 32'(oe_any[3][10]), 32'h0);
    check("R6", "data during disable", 32'(tx_cap[3][10]), 32'h0);
    check("R6", "slot outside window", 32'(tx_cap[0][0]), 32'(prev_rx[3][127]));
    next_frame();
    check("R6", "route resumes", 32'(tx_cap[3][10]), 32'(prev_rx[0][0]));
    check("R6", "oe resumes", 32'(oe_all[3][10]), 32'h1);
  endtask

  task automatic t_loopback();
    add_op(0, 1'b1, 10'h200, 10'h001);
    add_op(1, 1'b1, adr(0, 3), ent(1'b1, 1, 9));
    add_op(2, 1'b1, adr(2, 5), ent(1'b1, 0, 3));
    add_op(3, 1'b0, 10'h200, '0);
    next_frame();
    hold_h = last_rx[1][9];
    check("R9", "control readback", 32'(op_rd[3]), 32'h1);
    next_frame();
    check("R3", "s0c3 from s1c9", 32'(tx_cap[0][3]), 32'(hold_h));
    next_frame();
    check("R8", "looped byte, pin ignored", 32'(tx_cap[2][5]), 32'(hold_h));
    add_op(0, 1'b1, 10'h200, 10'h000);
    next_frame();
    hold_k = last_rx[0][3];
    next_frame();
    check("R8", "pin restored after clear", 32'(tx_cap[2][5]), 32'(hold_k));
  endtask

  initial begin
    rst_n = 1'b0; frame_pulse = 1'b0; out_disable = 1'b0;
    host_cs = 1'b0; host_we = 1'b0; host_addr = '0; host_wdata = '0; rx_ser = '0;
    repeat (4) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    #1;
    t_reset();
    t_route();
    t_midframe();
    t_disable();
    t_loopback();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(100000 * 5);
    total++; bad++;
    $display("FAIL watchdog R2 actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule